// File: doc/BRIEF.md
# Binary Morphological Cell Array

This block cleans up a one-bit-per-pixel change mask by running a short stored program over it. Each pixel of the frame has its own cell, and all cells are identical. A cell holds an input bit and a state bit. It samples a five-bit neighbourhood in one of two shapes, compares that neighbourhood against two programmable patterns, and combines two selected operands in a one-bit ALU. A sequencer reads one instruction at a time from a small program memory and broadcasts it to every cell at once, so every cell updates on the same edge.

Software-side logic writes the program word by word and then writes the frame row by row into the input bits. A single-cycle start pulse copies the input bits into the state bits and runs the program until it reaches a halt word or the end of memory. When the run ends, a done flag rises, and the resulting frame can be read back one row at a time. Dilation, erosion and a three-of-five majority are ordinary instruction words. Noise-cleanup chains such as dilate, erode ×3, dilate ×2, median are therefore just memory contents. The frame is 16×16 by default, and 64×64 is the nominal production size.

Top module: `morph_array`

## Requirements
- R1: After reset, `busy` and `done` are low and every row read through `rd_data` is all zeros.
- R2: When `busy` is low, `load_en` writes `load_data` into the input bits of row `load_row`, with bit c going to column c. A write attempted while `busy` is high is ignored.
- R3: A `start` pulse while `busy` is low copies every input bit into its state bit, raises `busy` on the next cycle, clears `done`, and starts execution at program address 0. A `start` pulse while `busy` is high has no effect.
- R4: Each 18-bit instruction word has these fields: bit 17 halt, bit 16 shape (0 = plus, 1 = diagonal), bits 15:14 ALU op, bits 13:12 operand A source, bits 11:10 operand B source, bits 9:5 pattern A, bits 4:0 pattern B.
- R5: The five-bit neighbourhood vector is ordered from bit 4 down to bit 0. For the plus shape it is {west, south, east, north, centre}. For the diagonal shape it is {south-west, south-east, north-east, north-west, centre}. Row 0 is the northern edge, and column 0 is the western edge.
- R6: A neighbour position that lies outside the array reads as 0.
- R7: Operand source codes: 0 selects the match of the neighbourhood against the operand's own pattern (A against pattern A, B against pattern B). 1 selects the state bit. 2 selects the input bit. 3 selects the majority, which is 1 when at least three of the five neighbourhood bits are 1.
- R8: ALU codes are 0 AND, 1 OR, 2 NOR, 3 XOR. Each executed instruction writes its ALU result into every cell's state bit at the same time, using operands sampled from the previous state.
- R9: Each executed instruction takes two cycles. A halt word at address N makes `done` rise 2N+1 rising edges after the start edge. A program with no halt word runs all DEPTH words, and `done` rises 2·DEPTH edges after the start edge.
- R10: Once `done` is high, it stays high and the state frame stays unchanged until the next accepted `start`. `rd_data` shows the state bits of row `rd_row` combinationally.
- R11: `prog_we` writes `prog_data` into program address `prog_addr` only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Frame row write strobe |
| load_row | input | RW | Row addressed by a frame write |
| load_data | input | COLS | Pixel bits for the addressed row |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | AW | Program memory address |
| prog_data | input | 18 | Instruction word |
| start | input | 1 | Single-cycle run request |
| rd_row | input | RW | Row selected for readout |
| rd_data | output | COLS | State bits of the selected row |
| busy | output | 1 | Program is executing |
| done | output | 1 | Last run has finished |

## Verification
The assertions assume that `start` is a one-cycle pulse and that `rd_row` stays within the array. They also assume that the result frame changes only through an accepted start, so a done state followed by no start must hold every state bit steady. The bench drives all inputs on falling edges and pulses `start` for exactly one cycle. It also aims its stray writes and stray start pulses at the middle of a run, which is where they must be ignored. Every expected frame comes from a bench-side model of the instruction semantics. Every expected latency comes from the 2N+1 and 2·DEPTH rules.

// File: rtl/morph_pkg.sv
package morph_pkg;

  localparam int NB_W = 5;

  typedef enum logic [1:0] {ALU_AND = 2'd0, ALU_OR = 2'd1, ALU_NOR = 2'd2, ALU_XOR = 2'd3} alu_e;
  typedef enum logic [1:0] {SRC_CMP = 2'd0, SRC_STATE = 2'd1, SRC_INPUT = 2'd2, SRC_MAJ = 2'd3} src_e;

  typedef struct packed {
    logic            halt;
    logic            shape;
    alu_e            alu;
    src_e            a_sel;
    src_e            b_sel;
    logic [NB_W-1:0] pat_a;
    logic [NB_W-1:0] pat_b;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  typedef struct packed {
    logic            copy_u;
    logic            eval_en;
    logic            commit_en;
    logic            shape;
    alu_e            alu;
    src_e            a_sel;
    src_e            b_sel;
    logic [NB_W-1:0] pat_a;
    logic [NB_W-1:0] pat_b;
  } ctrl_t;

  function automatic logic alu_fn(alu_e op, logic a, logic b);
    unique case (op)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_NOR: return ~(a | b);
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic majority(logic [NB_W-1:0] v);
    return ($countones(v) >= 3);
  endfunction

  function automatic logic pick(src_e sel, logic cmp, logic xs, logic us, logic maj);
    unique case (sel)
      SRC_CMP:   return cmp;
      SRC_STATE: return xs;
      SRC_INPUT: return us;
      default:   return maj;
    endcase
  endfunction

endpackage

// File: rtl/morph_cell.sv
module morph_cell
  import morph_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrl_t                ctl,
  input  logic                 u_we,
  input  logic                 u_in,
  input  logic [7:0]           ring,   // N,NE,E,SE,S,SW,W,NW at bits 0..7
  output logic                 x_out
);

  logic u_q, x_q, ta_q, tb_q;
  logic u_n, x_n, ta_n, tb_n;
  logic [NB_W-1:0] nb;
  logic cmp_a, cmp_b, maj, op_a, op_b;

  always_comb begin
    if (ctl.shape) nb = {ring[5], ring[3], ring[1], ring[7], x_q};
    else           nb = {ring[6], ring[4], ring[2], ring[0], x_q};
    cmp_a = (nb == ctl.pat_a);
    cmp_b = (nb == ctl.pat_b);
    maj   = majority(nb);
    op_a  = pick(ctl.a_sel, cmp_a, x_q, u_q, maj);
    op_b  = pick(ctl.b_sel, cmp_b, x_q, u_q, maj);
  end

  always_comb begin
    u_n  = u_we ? u_in : u_q;
    ta_n = ctl.eval_en ? op_a : ta_q;
    tb_n = ctl.eval_en ? op_b : tb_q;
    if (ctl.copy_u)         x_n = u_q;
    else if (ctl.commit_en) x_n = alu_fn(ctl.alu, ta_q, tb_q);
    else                    x_n = x_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q  <= 1'b0;
      x_q  <= 1'b0;
      ta_q <= 1'b0;
      tb_q <= 1'b0;
    end else begin
      u_q  <= u_n;
      x_q  <= x_n;
      ta_q <= ta_n;
      tb_q <= tb_n;
    end
  end

  assign x_out = x_q;

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.eval_en && ctl.commit_en) && !(ctl.copy_u && ctl.commit_en)); // R9

endmodule

// File: rtl/morph_seq.sv
module morph_seq
  import morph_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output ctrl_t              ctl,
  output logic               busy,
  output logic               done
);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_COMMIT, S_DONE} state_e;

  state_e state_q, state_n;
  logic [AW-1:0] pc_q, pc_n;
  logic [INSTR_W-1:0] mem [DEPTH];
  instr_t cur;

  assign cur  = instr_t'(mem[pc_q]);
  assign busy = (state_q == S_EVAL) || (state_q == S_COMMIT);
  assign done = (state_q == S_DONE);

  always_ff @(posedge clk) begin
    if (prog_we && !busy) mem[prog_addr] <= prog_data;
  end

  always_comb begin
    state_n = state_q;
    pc_n    = pc_q;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (start) begin
          state_n = S_EVAL;
          pc_n    = '0;
        end
      end
      S_EVAL:   state_n = cur.halt ? S_DONE : S_COMMIT;
      default: begin
        pc_n    = pc_q + 1'b1;
        state_n = (pc_q == AW'(DEPTH - 1)) ? S_DONE : S_EVAL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pc_q    <= '0;
    end else begin
      state_q <= state_n;
      pc_q    <= pc_n;
    end
  end

  always_comb begin
    ctl.copy_u    = start && !busy;
    ctl.eval_en   = (state_q == S_EVAL) && !cur.halt;
    ctl.commit_en = (state_q == S_COMMIT);
    ctl.shape     = cur.shape;
    ctl.alu       = cur.alu;
    ctl.a_sel     = cur.a_sel;
    ctl.b_sel     = cur.b_sel;
    ctl.pat_a     = cur.pat_a;
    ctl.pat_b     = cur.pat_b;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R3
  AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.commit_en |-> $past(ctl.eval_en)); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

endmodule

// File: rtl/morph_array.sv
module morph_array
  import morph_pkg::*;
#(
  parameter int ROWS  = 16,
  parameter int COLS  = 16,
  parameter int DEPTH = 8,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [RW-1:0]      load_row,
  input  logic [COLS-1:0]    load_data,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               start,
  input  logic [RW-1:0]      rd_row,
  output logic [COLS-1:0]    rd_data,
  output logic               busy,
  output logic               done
);

  logic [1:0] rs_q;
  logic rst_core_n;
  ctrl_t ctl;
  logic xs  [ROWS][COLS];
  logic pad [ROWS+2][COLS+2];
  logic [ROWS*COLS-1:0] x_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  morph_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .ctl       (ctl),
    .busy      (busy),
    .done      (done)
  );

  for (genvar pr = 0; pr < ROWS + 2; pr++) begin : g_pad_r
    for (genvar pcl = 0; pcl < COLS + 2; pcl++) begin : g_pad_c
      if (pr == 0 || pr == ROWS + 1 || pcl == 0 || pcl == COLS + 1) begin : g_edge
        assign pad[pr][pcl] = 1'b0;
      end else begin : g_core
        assign pad[pr][pcl] = xs[pr-1][pcl-1];
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [7:0] ring;
      assign ring = {pad[r][c],     pad[r+1][c],   pad[r+2][c], pad[r+2][c+1],
                     pad[r+2][c+2], pad[r+1][c+2], pad[r][c+2], pad[r][c+1]};
      morph_cell u_cell (
        .clk   (clk),
        .rst_n (rst_core_n),
        .ctl   (ctl),
        .u_we  (load_en && !busy && (load_row == RW'(r))),
        .u_in  (load_data[c]),
        .ring  (ring),
        .x_out (xs[r][c])
      );
      assign x_flat[r*COLS+c] = xs[r][c];
    end
  end

  always_comb begin
    for (int c = 0; c < COLS; c++) rd_data[c] = xs[rd_row][c];
  end

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done && !start) |=> $stable(x_flat)); // R10
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(done) |-> $past(busy)); // R9

endmodule

// File: tb/morph_array_bench.sv
module morph_array_bench;
  localparam int ROWS = 16;
  localparam int COLS = 16;
  localparam int DEPTH = 8;
  localparam int CLK_PERIOD = 10;
  localparam int RW = $clog2(ROWS);
  localparam int AW = $clog2(DEPTH);

  localparam logic [1:0] OP_AND = 2'd0, OP_OR = 2'd1, OP_NOR = 2'd2, OP_XOR = 2'd3;
  localparam logic [1:0] SEL_CMP = 2'd0, SEL_STATE = 2'd1, SEL_INPUT = 2'd2, SEL_MAJ = 2'd3;

  logic clk, rst_n, load_en, prog_we, start, busy, done;
  logic [RW-1:0] load_row, rd_row;
  logic [COLS-1:0] load_data, rd_data;
  logic [AW-1:0] prog_addr;
  logic [17:0] prog_data;

  int checks = 0;
  int errors = 0;

  bit u_img [ROWS][COLS];
  bit mx [ROWS][COLS];
  bit mn [ROWS][COLS];
  logic [17:0] prog_img [DEPTH];

  morph_array #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH)) u_morph_array (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
    .load_data(load_data), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .rd_row(rd_row), .rd_data(rd_data),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] enc(bit halt, bit shape, logic [1:0] alu,
                                      logic [1:0] a, logic [1:0] b,
                                      logic [4:0] pa, logic [4:0] pb);
    return {halt, shape, alu, a, b, pa, pb};
  endfunction

  function automatic logic [17:0] i_halt();
    return enc(1, 0, 0, 0, 0, 0, 0);
  endfunction
  function automatic logic [17:0] i_dil(bit s);
    return enc(0, s, OP_NOR, SEL_CMP, SEL_CMP, 5'h00, 5'h00);
  endfunction
  function automatic logic [17:0] i_ero(bit s);
    return enc(0, s, OP_AND, SEL_CMP, SEL_CMP, 5'h1f, 5'h1f);
  endfunction
  function automatic logic [17:0] i_med(bit s);
    return enc(0, s, OP_OR, SEL_MAJ, SEL_MAJ, 5'h00, 5'h00);
  endfunction
  function automatic logic [17:0] i_iso();
    return enc(0, 0, OP_XOR, SEL_CMP, SEL_STATE, 5'b00001, 5'h00);
  endfunction

  function automatic bit gx(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 1'b0;
    return mx[r][c];
  endfunction

  function automatic logic [4:0] nbv(int r, int c, bit s);
    if (s) return {gx(r+1,c-1), gx(r+1,c+1), gx(r-1,c+1), gx(r-1,c-1), gx(r,c)};
    return {gx(r,c-1), gx(r+1,c), gx(r,c+1), gx(r-1,c), gx(r,c)};
  endfunction

  function automatic bit srcv(logic [1:0] sel, logic [4:0] nb, logic [4:0] pat, int r, int c);
    case (sel)
      SEL_CMP:   return (nb == pat);
      SEL_STATE: return mx[r][c];
      SEL_INPUT: return u_img[r][c];
      default:   return ($countones(nb) >= 3);
    endcase
  endfunction

  function automatic bit alum(logic [1:0] op, bit a, bit b);
    case (op)
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_NOR:  return ~(a | b);
      default: return a ^ b;
    endcase
  endfunction

  task automatic model_apply(logic [17:0] w);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) begin
        logic [4:0] nb;
        nb = nbv(r, c, w[16]);
        mn[r][c] = alum(w[15:14], srcv(w[13:12], nb, w[9:5], r, c),
                                  srcv(w[11:10], nb, w[4:0], r, c));
      end
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mx[r][c] = mn[r][c];
  endtask

  task automatic model_run(output int nexec);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) mx[r][c] = u_img[r][c];
    nexec = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (prog_img[i][17]) break;
      model_apply(prog_img[i]);
      nexec++;
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_program();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = AW'(i); prog_data = prog_img[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic load_frame();
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      load_en = 1'b1; load_row = RW'(r);
      for (int c = 0; c < COLS; c++) load_data[c] = u_img[r][c];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic check_frame(string req);
    int bad = 0;
    logic [COLS-1:0] act_row = '0, exp_row = '0;
    for (int r = 0; r < ROWS; r++) begin
      logic [COLS-1:0] e;
      rd_row = RW'(r);
      #1;
      for (int c = 0; c < COLS; c++) e[c] = mx[r][c];
      if (rd_data !== e && bad == 0) begin act_row = rd_data; exp_row = e; end
      if (rd_data !== e) bad++;
    end
    chk(bad == 0, req, "result frame first bad row", int'(act_row), int'(exp_row));
  endtask

  task automatic run_check(string req, bit poke_start, bit poke_write);
    int nexec, lat_exp, edges;
    model_run(nexec);
    lat_exp = (nexec < DEPTH) ? 2*nexec + 1 : 2*DEPTH;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    edges = 1;
    chk(busy === 1'b1 && done === 1'b0, "R3", "busy/done after start", {busy, done}, 2'b10);
    while (!done && edges < 200) begin
      if (edges == 2) begin
        start = poke_start;
        if (poke_write) begin
          load_en = 1'b1; load_row = RW'(3); load_data = '1;
          prog_we = 1'b1; prog_addr = '0; prog_data = i_halt();
        end
      end else begin
        start = 1'b0; load_en = 1'b0; prog_we = 1'b0;
      end
      @(negedge clk);
      edges++;
    end
    start = 1'b0; load_en = 1'b0; prog_we = 1'b0;
    chk(edges - 1 == lat_exp, "R9", "done latency", edges - 1, lat_exp);
    check_frame(req);
  endtask

  task automatic set_prog(logic [17:0] p0, logic [17:0] p1, logic [17:0] p2, logic [17:0] p3,
                          logic [17:0] p4, logic [17:0] p5, logic [17:0] p6, logic [17:0] p7);
    prog_img[0] = p0; prog_img[1] = p1; prog_img[2] = p2; prog_img[3] = p3;
    prog_img[4] = p4; prog_img[5] = p5; prog_img[6] = p6; prog_img[7] = p7;
    write_program();
  endtask

  task automatic fill(int pct);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) u_img[r][c] = ($urandom_range(0, 99) < pct);
  endtask

  task automatic clear_img();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) u_img[r][c] = 1'b0;
  endtask

  task automatic t_reset();
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset", {busy, done}, 0);
    for (int r = 0; r < ROWS; r++) begin
      rd_row = RW'(r); #1;
      chk(rd_data === '0, "R1", "row after reset", int'(rd_data), 0);
    end
  endtask

  task automatic t_copy_only();
    fill(40); load_frame();
    set_prog(i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R2", 0, 0);
    chk(done === 1'b1 && busy === 1'b0, "R10", "done held", {busy, done}, 1);
  endtask

  task automatic t_shapes();
    clear_img(); u_img[5][5] = 1'b1; u_img[10][3] = 1'b1; load_frame();
    set_prog(i_dil(0), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R5", 0, 0);
    rd_row = RW'(4); #1;
    chk(rd_data === 16'h0020, "R5", "plus dilation north arm", int'(rd_data), 'h20);
    set_prog(i_dil(1), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R5", 0, 0);
    rd_row = RW'(4); #1;
    chk(rd_data === 16'h0050, "R5", "diagonal dilation upper pair", int'(rd_data), 'h50);
  endtask

  task automatic t_border();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) u_img[r][c] = 1'b1;
    load_frame();
    set_prog(i_ero(0), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R6", 0, 0);
    rd_row = RW'(0); #1;
    chk(rd_data === '0, "R6", "top row eroded by outside zeros", int'(rd_data), 0);
    rd_row = RW'(5); #1;
    chk(rd_data === 16'h7ffe, "R6", "side columns eroded", int'(rd_data), 'h7ffe);
    clear_img(); u_img[0][0] = 1'b1; load_frame();
    set_prog(i_dil(1), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R6", 0, 0);
  endtask

  task automatic t_ops();
    fill(50); load_frame();
    set_prog(i_med(0), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R7", 0, 0);
    set_prog(i_med(1), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R7", 0, 0);
    fill(15); load_frame();
    set_prog(i_iso(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R8", 0, 0);
    set_prog(i_dil(0), enc(0, 0, OP_XOR, SEL_STATE, SEL_INPUT, 5'h00, 5'h00), i_halt(),
             i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R8", 0, 0);
  endtask

  task automatic t_cleanup();
    fill(30); load_frame();
    set_prog(i_dil(0), i_ero(0), i_ero(0), i_ero(0), i_dil(0), i_dil(0), i_med(0), i_halt());
    run_check("R4", 1, 0);
  endtask

  task automatic t_full_depth();
    fill(35); load_frame();
    set_prog(i_dil(0), i_ero(0), i_dil(1), i_ero(1), i_med(0), i_med(1), i_iso(), i_dil(0));
    run_check("R9", 0, 0);
  endtask

  task automatic t_busy_writes();
    fill(45); load_frame();
    set_prog(i_dil(0), i_ero(0), i_ero(1), i_halt(), i_halt(), i_halt(), i_halt(), i_halt());
    run_check("R11", 1, 1);
    run_check("R2", 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; prog_we = 1'b0; start = 1'b0;
    load_row = '0; rd_row = '0; load_data = '0; prog_addr = '0; prog_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_copy_only();
    t_shapes();
    t_border();
    t_ops();
    t_cleanup();
    t_full_depth();
    t_busy_writes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule